// File: doc/BRIEF.md
# Debounced Quadrature Position Counter

This block keeps a signed position count that follows a two-pin motion input and a third auxiliary pin. The two count pins can be read in four ways: as a Gray-coded quadrature pair from an encoder, as a plain 2-bit binary code from a thumbwheel, as a count strobe with a level that sets the direction, or as two independent strobes, one counting up and one counting down. Before any decoding, every pin goes through a glitch filter whose hold-off length is set by a configuration input.

The third pin plays one of two roles. In marker role its rising edge returns the count to zero and leaves a sticky marker flag. In button role its rising edge only produces a one-cycle press pulse. Two signed limits bound the count. In auto-zero mode a step that lands on or beyond either limit clears the count. In flag mode the count keeps going and a sticky boundary flag is raised. Every applied step also produces a one-cycle event pulse, so that an external timer can measure the spacing of counts.

Internally, a small state machine remembers the last filtered pin pair. Its four states are PH_00, PH_01, PH_10 and PH_11. Each cycle it takes one of four transitions: step-up, step-down, skip (an illegal jump, which raises the error flag) or hold. A separate counter stage applies the step, the limit handling and the marker or button role.

Top module: `qcount_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, count is 0, err_flag, zm_flag and bnd_flag are 0, and count_evt and btn_press are low.
- R2: With mode 0 (quadrature) and code {in_a,in_b}, the sequence 00→01→11→10→00 counts up by one per transition and the reverse order counts down by one.
- R3: In quadrature mode a transition in which both bits change leaves the count unchanged, gives no count_evt and sets err_flag, which stays set until clr_flags.
- R4: With mode 1 (binary), a code change of +1 modulo 4 counts up, −1 modulo 4 counts down, and +2 modulo 4 leaves the count unchanged and sets err_flag.
- R5: With mode 2 (level direction), a rising edge of filtered in_a counts up when filtered in_b is 1 and down when it is 0; a falling edge of in_a and any change of in_b have no effect on count.
- R6: With mode 3 (edge pair), a rising edge of in_a counts up and a rising edge of in_b counts down; both rising in the same cycle change nothing and give no count_evt.
- R7: Each pin filter passes a new level only after the raw pin has differed from the filtered level for db_len+1 consecutive clock edges; a shorter glitch is ignored. With db_len = 0, count changes at the second rising clock edge after the raw pin changes.
- R8: count_evt is high for exactly one cycle for each applied step, in the same cycle as the count update; a marker clear gives no count_evt.
- R9: With z_role = 0 (marker), a rising edge of filtered in_z sets count to 0 and sets zm_flag; it takes precedence over a step in the same cycle.
- R10: With z_role = 1 (button), a rising edge of filtered in_z gives a one-cycle btn_press and leaves count and zm_flag unchanged.
- R11: With bnd_mode = 0 (auto-zero), a step whose signed result is ≥ bnd_upper or ≤ bnd_lower sets count to 0 instead, and bnd_flag stays 0.
- R12: With bnd_mode = 1 (flag), such a step still updates count to its result and sets bnd_flag, which stays set until clr_flags.
- R13: A one-cycle clr_flags pulse clears err_flag, zm_flag and bnd_flag without changing count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_a | input | 1 | Count pin A (synchronous to clk) |
| in_b | input | 1 | Count pin B (synchronous to clk) |
| in_z | input | 1 | Auxiliary pin: zero marker or push-button |
| mode | input | 2 | 0 quadrature, 1 binary, 2 level direction, 3 edge pair |
| db_len | input | DB_W | Filter hold-off length, 0 to 255 |
| z_role | input | 1 | 0 marker clears count, 1 button pulse |
| bnd_mode | input | 1 | 0 auto-zero, 1 sticky boundary flag |
| bnd_upper | input | COUNT_W | Signed upper limit |
| bnd_lower | input | COUNT_W | Signed lower limit |
| clr_flags | input | 1 | Clears the three sticky flags |
| count | output | COUNT_W | Signed position count |
| count_evt | output | 1 | One-cycle pulse per applied step |
| btn_press | output | 1 | One-cycle pulse on button press |
| err_flag | output | 1 | Sticky illegal-transition flag |
| zm_flag | output | 1 | Sticky zero-marker flag |
| bnd_flag | output | 1 | Sticky limit flag |

## Verification
The quadrature decoder is driven through a full forward cycle, a reversal and a two-bit jump. This separates a correct Gray ordering from a swapped pin order or a missing error path. Binary mode is driven through codes that are legal there but illegal in quadrature (01→10), which exposes a decoder that ignores the mode. The two strobe modes get falling edges and simultaneous rising edges that must do nothing. The filter gets a glitch that is one short of the hold-off and then an edge timed to the exact cycle. The limits are approached from both sides in each boundary mode, and the auxiliary pin is pulsed in both roles.

// File: rtl/qc_pkg.sv
package qc_pkg;

    typedef enum logic [1:0] {
        IN_QUAD   = 2'd0,
        IN_BIN    = 2'd1,
        IN_DIRLVL = 2'd2,
        IN_EDGES  = 2'd3
    } in_mode_e;

    // last filtered {a,b} pair seen by the decoder
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_10 = 2'b10,
        PH_11 = 2'b11
    } phase_e;

    // position of a code along the Gray cycle 00,01,11,10
    function automatic logic [1:0] gray_pos(input logic [1:0] c);
        return {c[1], c[1] ^ c[0]};
    endfunction

endpackage

// File: rtl/qc_debounce.sv
module qc_debounce #(
    parameter int DB_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DB_W-1:0] len,
    input  logic            raw,
    output logic            filt
);
    logic [DB_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt  <= 1'b0;
            run_q <= '0;
        end else if (raw == filt) begin
            run_q <= '0;
        end else if (run_q >= len) begin
            filt  <= raw;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/qc_decode.sv
module qc_decode
    import qc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic [1:0] code,
    output logic       step_up,
    output logic       step_dn,
    output logic       bad
);
    phase_e     phase_q;
    logic [1:0] prev;
    logic [1:0] diff;
    logic       a_rise;
    logic       b_rise;

    // state register: remembers the last filtered pair
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_00;
        else        phase_q <= phase_e'(code);
    end

    assign prev   = phase_q;
    assign a_rise = code[1] & ~prev[1];
    assign b_rise = code[0] & ~prev[0];

    // outputs: step-up, step-down, skip (bad) or hold
    always_comb begin
        step_up = 1'b0;
        step_dn = 1'b0;
        bad     = 1'b0;
        diff    = '0;
        unique case (in_mode_e'(mode))
            IN_QUAD: begin
                diff    = gray_pos(code) - gray_pos(prev);
                step_up = (diff == 2'd1);
                step_dn = (diff == 2'd3);
                bad     = (diff == 2'd2);
            end
            IN_BIN: begin
                diff    = code - prev;
                step_up = (diff == 2'd1);
                step_dn = (diff == 2'd3);
                bad     = (diff == 2'd2);
            end
            IN_DIRLVL: begin
                step_up = a_rise & code[0];
                step_dn = a_rise & ~code[0];
            end
            IN_EDGES: begin
                step_up = a_rise & ~b_rise;
                step_dn = b_rise & ~a_rise;
            end
        endcase
    end
endmodule

// File: rtl/qc_core.sv
module qc_core #(
    parameter int COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_up,
    input  logic               step_dn,
    input  logic               bad,
    input  logic               z_filt,
    input  logic               z_role,
    input  logic               bnd_mode,
    input  logic [COUNT_W-1:0] bnd_upper,
    input  logic [COUNT_W-1:0] bnd_lower,
    input  logic               clr_flags,
    output logic [COUNT_W-1:0] count,
    output logic               count_evt,
    output logic               btn_press,
    output logic               err_flag,
    output logic               zm_flag,
    output logic               bnd_flag
);
    logic               z_q;
    logic               z_rise;
    logic               step;
    logic               hit;
    logic [COUNT_W-1:0] next_val;

    assign z_rise = z_filt & ~z_q;
    assign step   = step_up | step_dn;

    always_comb begin
        next_val = step_up ? count + 1'b1 : count - 1'b1;
        hit = ($signed(next_val) >= $signed(bnd_upper)) ||
              ($signed(next_val) <= $signed(bnd_lower));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count     <= '0;
            count_evt <= 1'b0;
            btn_press <= 1'b0;
            err_flag  <= 1'b0;
            zm_flag   <= 1'b0;
            bnd_flag  <= 1'b0;
            z_q       <= 1'b0;
        end else begin
            z_q       <= z_filt;
            count_evt <= 1'b0;
            btn_press <= z_rise & z_role;
            if (clr_flags) begin
                err_flag <= 1'b0;
                zm_flag  <= 1'b0;
                bnd_flag <= 1'b0;
            end
            if (bad) err_flag <= 1'b1;
            if (z_rise && !z_role) begin
                count   <= '0;
                zm_flag <= 1'b1;
            end else if (step) begin
                count_evt <= 1'b1;
                count     <= (hit && !bnd_mode) ? '0 : next_val;
                if (hit && bnd_mode) bnd_flag <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/qcount_top.sv
module qcount_top #(
    parameter int COUNT_W = 32,
    parameter int DB_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_a,
    input  logic               in_b,
    input  logic               in_z,
    input  logic [1:0]         mode,
    input  logic [DB_W-1:0]    db_len,
    input  logic               z_role,
    input  logic               bnd_mode,
    input  logic [COUNT_W-1:0] bnd_upper,
    input  logic [COUNT_W-1:0] bnd_lower,
    input  logic               clr_flags,
    output logic [COUNT_W-1:0] count,
    output logic               count_evt,
    output logic               btn_press,
    output logic               err_flag,
    output logic               zm_flag,
    output logic               bnd_flag
);
    localparam int NPINS = 3;

    logic [NPINS-1:0] raw;
    logic [NPINS-1:0] filt;
    logic             dec_up;
    logic             dec_dn;
    logic             dec_bad;

    assign raw = {in_a, in_b, in_z};

    for (genvar i = 0; i < NPINS; i++) begin : g_filt
        qc_debounce #(.DB_W(DB_W)) u_db (
            .clk  (clk),
            .rst_n(rst_n),
            .len  (db_len),
            .raw  (raw[i]),
            .filt (filt[i])
        );
    end

    qc_decode u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .code   (filt[2:1]),
        .step_up(dec_up),
        .step_dn(dec_dn),
        .bad    (dec_bad)
    );

    qc_core #(.COUNT_W(COUNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_up  (dec_up),
        .step_dn  (dec_dn),
        .bad      (dec_bad),
        .z_filt   (filt[0]),
        .z_role   (z_role),
        .bnd_mode (bnd_mode),
        .bnd_upper(bnd_upper),
        .bnd_lower(bnd_lower),
        .clr_flags(clr_flags),
        .count    (count),
        .count_evt(count_evt),
        .btn_press(btn_press),
        .err_flag (err_flag),
        .zm_flag  (zm_flag),
        .bnd_flag (bnd_flag)
    );
endmodule

// File: rtl/qcount_chk.sv
module qcount_chk #(
    parameter int COUNT_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         raw,
    input logic [2:0]         filt,
    input logic               dec_bad,
    input logic               z_role,
    input logic               bnd_mode,
    input logic [COUNT_W-1:0] bnd_upper,
    input logic [COUNT_W-1:0] bnd_lower,
    input logic [COUNT_W-1:0] count,
    input logic               count_evt,
    input logic               err_flag,
    input logic               clr_flags
);
    AST_FILT_TAKES_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        ((filt ^ $past(filt)) & (filt ^ $past(raw))) == 3'b000); // R7

    AST_BAD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        dec_bad |=> (!count_evt && err_flag)); // R3

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr_flags) |=> err_flag); // R3

    AST_COUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !count_evt |-> ($stable(count) || count == '0)); // R8

    AST_MARKER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (filt[0] && !$past(filt[0]) && !z_role) |=> (count == '0)); // R9

    AST_AZ_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (count_evt && !bnd_mode && $signed(bnd_upper) > 0 && $signed(bnd_lower) < 0)
        |-> ($signed(count) < $signed(bnd_upper) && $signed(count) > $signed(bnd_lower))); // R11
endmodule

bind qcount_top qcount_chk #(.COUNT_W(COUNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw      (raw),
    .filt     (filt),
    .dec_bad  (dec_bad),
    .z_role   (z_role),
    .bnd_mode (bnd_mode),
    .bnd_upper(bnd_upper),
    .bnd_lower(bnd_lower),
    .count    (count),
    .count_evt(count_evt),
    .err_flag (err_flag),
    .clr_flags(clr_flags)
);

// File: tb/test_qcount_top.sv
module test_qcount_top;
    localparam int CW = 32;
    localparam int DW = 8;

    typedef struct packed {
        logic        a;
        logic        b;
        logic [31:0] cnt;
        logic        err;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 32'd1, 1'b0},
        '{1'b1, 1'b1, 32'd2, 1'b0},
        '{1'b1, 1'b0, 32'd3, 1'b0},
        '{1'b0, 1'b0, 32'd4, 1'b0},
        '{1'b1, 1'b0, 32'd3, 1'b0},
        '{1'b1, 1'b1, 32'd2, 1'b0},
        '{1'b0, 1'b0, 32'd2, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_a = 1'b0, in_b = 1'b0, in_z = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [DW-1:0] db_len = '0;
    logic          z_role = 1'b0, bnd_mode = 1'b0, clr_flags = 1'b0;
    logic [CW-1:0] bnd_upper = 32'h7FFF_FFFF;
    logic [CW-1:0] bnd_lower = 32'h8000_0000;
    logic [CW-1:0] count;
    logic          count_evt, btn_press, err_flag, zm_flag, bnd_flag;

    int n_chk = 0, n_fail = 0;
    int evt_seen = 0, btn_seen = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    qcount_top #(.COUNT_W(CW), .DB_W(DW)) i_qcount_top (
        .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_z(in_z),
        .mode(mode), .db_len(db_len), .z_role(z_role), .bnd_mode(bnd_mode),
        .bnd_upper(bnd_upper), .bnd_lower(bnd_lower), .clr_flags(clr_flags),
        .count(count), .count_evt(count_evt), .btn_press(btn_press),
        .err_flag(err_flag), .zm_flag(zm_flag), .bnd_flag(bnd_flag)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a negedge: drive the pins, then wait cyc cycles, counting pulses
    task automatic apply(input logic a, input logic b, input logic z, input int cyc);
        in_a = a; in_b = b; in_z = z;
        evt_seen = 0; btn_seen = 0;
        for (int i = 0; i < cyc; i++) begin
            @(posedge clk);
            @(negedge clk);
            evt_seen += int'(count_evt);
            btn_seen += int'(btn_press);
        end
    endtask

    task automatic do_reset(input logic [1:0] m, input int db);
        @(negedge clk);
        rst_n = 1'b0;
        in_a = 1'b0; in_b = 1'b0; in_z = 1'b0;
        mode = m; db_len = DW'(db);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_clear();
        clr_flags = 1'b1;
        @(negedge clk);
        clr_flags = 1'b0;
        @(negedge clk);
    endtask

    function automatic longint sc(input logic [CW-1:0] v);
        return longint'($signed(v));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset(2'd0, 0);
        chk("R1 count", sc(count), 0);
        chk("R1 flags", {err_flag, zm_flag, bnd_flag}, 0);
        chk("R1 pulses", {count_evt, btn_press}, 0);
        @(negedge clk);
        chk("R1 count after release", sc(count), 0);

        // R2/R3: quadrature table
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].a, VECS[i].b, 1'b0, 3);
            chk($sformatf("R2 quad vec %0d count", i), sc(count), sc(VECS[i].cnt));
            chk($sformatf("R3 quad vec %0d err", i), err_flag, VECS[i].err);
        end
        chk("R3 no event on bad jump", evt_seen, 0);
        apply(1'b0, 1'b0, 1'b0, 4);
        chk("R3 err sticky", err_flag, 1);
        pulse_clear();
        chk("R13 clear err", err_flag, 0);
        chk("R13 count kept", sc(count), 2);

        // R7: latency with db_len 0
        do_reset(2'd0, 0);
        @(negedge clk);
        in_b = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R7 no change after 1 edge", sc(count), 0);
        @(posedge clk); @(negedge clk);
        chk("R7 change after 2 edges", sc(count), 1);
        chk("R8 evt with update", count_evt, 1);
        @(negedge clk);
        chk("R8 evt one cycle", count_evt, 0);

        // R4: binary mode
        do_reset(2'd1, 0);
        apply(1'b0, 1'b1, 1'b0, 3);
        apply(1'b1, 1'b0, 1'b0, 3);
        apply(1'b1, 1'b1, 1'b0, 3);
        apply(1'b0, 1'b0, 1'b0, 3);
        chk("R4 binary up four", sc(count), 4);
        chk("R4 no err on 01-10", err_flag, 0);
        apply(1'b1, 1'b1, 1'b0, 3);
        chk("R4 binary down", sc(count), 3);
        apply(1'b0, 1'b1, 1'b0, 3);
        chk("R4 jump of two count", sc(count), 3);
        chk("R4 jump of two err", err_flag, 1);

        // R5: level direction
        do_reset(2'd2, 0);
        apply(1'b0, 1'b1, 1'b0, 3);
        chk("R5 b change ignored", sc(count), 0);
        apply(1'b1, 1'b1, 1'b0, 3);
        chk("R5 a rise with b=1 up", sc(count), 1);
        apply(1'b0, 1'b1, 1'b0, 3);
        apply(1'b0, 1'b0, 1'b0, 3);
        chk("R5 a fall ignored", sc(count), 1);
        apply(1'b1, 1'b0, 1'b0, 3);
        apply(1'b0, 1'b0, 1'b0, 3);
        apply(1'b1, 1'b0, 1'b0, 3);
        chk("R5 a rise with b=0 down", sc(count), -1);
        chk("R5 wrap pattern", count, 32'hFFFF_FFFF);

        // R6/R8: edge pair
        do_reset(2'd3, 0);
        apply(1'b1, 1'b0, 1'b0, 3);
        chk("R6 a rise up", sc(count), 1);
        chk("R8 one evt per step", evt_seen, 1);
        apply(1'b0, 1'b0, 1'b0, 3);
        apply(1'b0, 1'b1, 1'b0, 3);
        chk("R6 b rise down", sc(count), 0);
        apply(1'b0, 1'b0, 1'b0, 3);
        apply(1'b1, 1'b1, 1'b0, 3);
        chk("R6 both rise count", sc(count), 0);
        chk("R6 both rise no evt", evt_seen, 0);

        // R7: filter length 5
        do_reset(2'd0, 5);
        apply(1'b0, 1'b1, 1'b0, 5);
        apply(1'b0, 1'b0, 1'b0, 10);
        chk("R7 short glitch ignored", sc(count), 0);
        apply(1'b0, 1'b1, 1'b0, 6);
        chk("R7 held before N+2 edges", sc(count), 0);
        apply(1'b0, 1'b1, 1'b0, 1);
        chk("R7 counted at N+2 edges", sc(count), 1);

        // R9: marker role
        do_reset(2'd0, 0);
        apply(1'b0, 1'b1, 1'b0, 3);
        apply(1'b1, 1'b1, 1'b0, 3);
        apply(1'b1, 1'b0, 1'b0, 3);
        chk("R9 before marker", sc(count), 3);
        apply(1'b1, 1'b0, 1'b1, 3);
        chk("R9 marker clears", sc(count), 0);
        chk("R9 marker flag", zm_flag, 1);
        chk("R8 no evt on marker", evt_seen, 0);
        apply(1'b1, 1'b0, 1'b0, 3);
        pulse_clear();
        chk("R13 clear zm", zm_flag, 0);

        // R10: button role
        z_role = 1'b1;
        do_reset(2'd0, 0);
        apply(1'b0, 1'b1, 1'b0, 3);
        apply(1'b0, 1'b1, 1'b1, 4);
        chk("R10 one press pulse", btn_seen, 1);
        chk("R10 count kept", sc(count), 1);
        chk("R10 no marker flag", zm_flag, 0);
        z_role = 1'b0;

        // R11: auto-zero
        bnd_upper = 32'd3; bnd_lower = -32'sd3; bnd_mode = 1'b0;
        do_reset(2'd0, 0);
        apply(1'b0, 1'b1, 1'b0, 3);
        apply(1'b1, 1'b1, 1'b0, 3);
        chk("R11 below upper", sc(count), 2);
        apply(1'b1, 1'b0, 1'b0, 3);
        chk("R11 reaching upper zeroes", sc(count), 0);
        chk("R11 evt on zeroing step", evt_seen, 1);
        apply(1'b1, 1'b1, 1'b0, 3);
        apply(1'b0, 1'b1, 1'b0, 3);
        chk("R11 down to -2", sc(count), -2);
        apply(1'b0, 1'b0, 1'b0, 3);
        chk("R11 reaching lower zeroes", sc(count), 0);
        chk("R11 no bnd flag", bnd_flag, 0);

        // R12: flag mode
        bnd_mode = 1'b1;
        do_reset(2'd0, 0);
        apply(1'b0, 1'b1, 1'b0, 3);
        apply(1'b1, 1'b1, 1'b0, 3);
        chk("R12 no flag inside", bnd_flag, 0);
        apply(1'b1, 1'b0, 1'b0, 3);
        chk("R12 count reaches 3", sc(count), 3);
        chk("R12 flag set", bnd_flag, 1);
        apply(1'b0, 1'b0, 1'b0, 3);
        chk("R12 keeps counting", sc(count), 4);
        chk("R12 flag sticky", bnd_flag, 1);
        pulse_clear();
        chk("R13 clear bnd", bnd_flag, 0);
        chk("R13 count untouched", sc(count), 4);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule